// File: doc/BRIEF.md
# DMA Protected Memory Range Filter

This block sits in the inbound path from bus masters and decides, for every request, whether it may reach memory. Two protected windows are programmable: a low window that must sit wholly under the 4 GB line and a high window of variable size that must sit wholly at or above it. A DMA request whose address falls inside an active window is blocked. Requests issued by the processor are never filtered.

Protection has its own global enable. It is independent of the address-remapping enable, so firmware can guard the memory that will hold the translation tables before translation is switched on. A blocked read returns all-ones data with an error. A blocked write is dropped with an error. A status flag reports that protection is on and that both windows carry a sane configuration. A window whose bounds break the 4 GB split, or whose base lies above its limit, is treated as switched off.

Top module: `dma_prot_filter`

## Requirements
- R1: After reset, dec_valid, dec_block, dec_err, dec_drop_wr, dec_to_xlate, dec_rdata and prot_ok are all zero, and no request is blocked until the configuration is written.
- R2: With the global enable and the low-window enable set, a DMA request whose page number (address bits 38:20) lies between the low base and the low limit, both inclusive, is reported with dec_block=1 one cycle after it is presented. Addresses one byte outside either end pass.
- R3: With the global enable and the high-window enable set, a DMA request inside the high window, with inclusive page bounds, is blocked one cycle later. Addresses just past the limit pass.
- R4: A request with req_is_dma=0 is never blocked, whatever its address.
- R5: With the global enable clear, no request is blocked, even when the window enables are set.
- R6: remap_en has no effect on dec_block. A DMA request that passes while remap_en=1 asserts dec_to_xlate. A blocked request, or one made with remap_en=0, does not.
- R7: A low window whose limit page is 4096 or higher, a high window whose base page is below 4096, or any window whose base exceeds its limit, is invalid and blocks nothing.
- R8: prot_ok is 1 exactly when the global enable is set and both windows hold a valid configuration. It changes in the cycle after the write that changes it.
- R9: A blocked read gives dec_err=1 with dec_rdata all ones. A blocked write gives dec_err=1 and dec_drop_wr=1. A passed request gives dec_err=0, dec_drop_wr=0 and dec_rdata=0.
- R10: Configuration writes use cfg_addr 0 for control (bit 0 global enable, bit 1 low-window enable, bit 2 high-window enable), 1 for low base, 2 for low limit, 3 for high base and 4 for high limit. The bound fields take the page number in cfg_wdata. Writes to any other cfg_addr change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration register select |
| cfg_wdata | input | 19 | Configuration write data (page number or control bits) |
| remap_en | input | 1 | Address remapping engine enabled |
| req_valid | input | 1 | Request present |
| req_is_dma | input | 1 | Request comes from a bus master (1) or from the processor (0) |
| req_write | input | 1 | Request is a write |
| req_addr | input | 39 | Request physical address |
| dec_valid | output | 1 | Decision present |
| dec_block | output | 1 | Request blocked |
| dec_err | output | 1 | Error response |
| dec_drop_wr | output | 1 | Write discarded |
| dec_to_xlate | output | 1 | Passed DMA request goes on to translation |
| dec_rdata | output | 64 | Read data returned for a blocked read |
| prot_ok | output | 1 | Protection enabled and both windows valid |

## Verification
The decision for a request is registered once, so its outputs are due one cycle after the request is presented. A configuration write lands in its register at the next edge, so prot_ok and every later decision see the new value from that cycle on. The bench drives each input on a falling edge and reads the outputs on the next falling edge, half a cycle after the register that produces them has updated. Every window bound is tested with the first and last byte inside it and with the byte just beyond it.

// File: rtl/dpf_pkg.sv
package dpf_pkg;
   typedef enum logic [2:0] {
      CSR_CTRL    = 3'd0,
      CSR_LO_BASE = 3'd1,
      CSR_LO_LIM  = 3'd2,
      CSR_HI_BASE = 3'd3,
      CSR_HI_LIM  = 3'd4
   } csr_sel_e;

   localparam int CTRL_GLOB = 0;
   localparam int CTRL_LO   = 1;
   localparam int CTRL_HI   = 2;
endpackage

// File: rtl/dpf_cfg.sv
module dpf_cfg #(
   parameter int PAGE_W = 19
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [2:0]        sel,
   input  logic [PAGE_W-1:0] wdata,
   output logic              glob_en,
   output logic              lo_en,
   output logic              hi_en,
   output logic [PAGE_W-1:0] lo_base,
   output logic [PAGE_W-1:0] lo_lim,
   output logic [PAGE_W-1:0] hi_base,
   output logic [PAGE_W-1:0] hi_lim
);
   import dpf_pkg::*;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         glob_en <= 1'b0;
         lo_en   <= 1'b0;
         hi_en   <= 1'b0;
         lo_base <= '0;
         lo_lim  <= '0;
         hi_base <= '0;
         hi_lim  <= '0;
      end else if (we) begin
         case (csr_sel_e'(sel))
            CSR_CTRL: begin
               glob_en <= wdata[CTRL_GLOB];
               lo_en   <= wdata[CTRL_LO];
               hi_en   <= wdata[CTRL_HI];
            end
            CSR_LO_BASE: lo_base <= wdata;
            CSR_LO_LIM:  lo_lim  <= wdata;
            CSR_HI_BASE: hi_base <= wdata;
            CSR_HI_LIM:  hi_lim  <= wdata;
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/dpf_window.sv
module dpf_window #(
   parameter int ADDR_W  = 39,
   parameter int GRAN_W  = 20,
   parameter bit IS_HIGH = 1'b0
) (
   input  logic [ADDR_W-GRAN_W-1:0] base,
   input  logic [ADDR_W-GRAN_W-1:0] lim,
   input  logic                     en,
   input  logic [ADDR_W-1:0]        addr,
   output logic                     cfg_ok,
   output logic                     hit
);
   localparam int PAGE_W = ADDR_W - GRAN_W;
   localparam logic [PAGE_W-1:0] SPLIT = PAGE_W'(1) << (32 - GRAN_W);

   logic              side_ok;
   logic [ADDR_W-1:0] lo_byte;
   logic [ADDR_W-1:0] hi_byte;

   generate
      if (IS_HIGH) begin : g_above
         assign side_ok = (base >= SPLIT);
      end else begin : g_below
         assign side_ok = (lim < SPLIT);
      end
   endgenerate

   assign lo_byte = {base, {GRAN_W{1'b0}}};
   assign hi_byte = {lim,  {GRAN_W{1'b1}}};
   assign cfg_ok  = side_ok && (base <= lim);
   assign hit     = en && cfg_ok && (addr >= lo_byte) && (addr <= hi_byte);
endmodule

// File: rtl/dpf_resp.sv
module dpf_resp #(
   parameter int DATA_W = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_is_dma,
   input  logic              req_write,
   input  logic              remap_en,
   input  logic              win_hit,
   output logic              dec_valid,
   output logic              dec_block,
   output logic              dec_err,
   output logic              dec_drop_wr,
   output logic              dec_to_xlate,
   output logic [DATA_W-1:0] dec_rdata
);
   logic blk;
   assign blk = req_valid && req_is_dma && win_hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dec_valid    <= 1'b0;
         dec_block    <= 1'b0;
         dec_err      <= 1'b0;
         dec_drop_wr  <= 1'b0;
         dec_to_xlate <= 1'b0;
         dec_rdata    <= '0;
      end else begin
         dec_valid    <= req_valid;
         dec_block    <= blk;
         dec_err      <= blk;
         dec_drop_wr  <= blk && req_write;
         dec_to_xlate <= req_valid && req_is_dma && !win_hit && remap_en;
         dec_rdata    <= (blk && !req_write) ? '1 : '0;
      end
   end
endmodule

// File: rtl/dma_prot_filter.sv
module dma_prot_filter #(
   parameter int ADDR_W = 39,
   parameter int GRAN_W = 20,
   parameter int DATA_W = 64
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     cfg_we,
   input  logic [2:0]               cfg_addr,
   input  logic [ADDR_W-GRAN_W-1:0] cfg_wdata,
   input  logic                     remap_en,
   input  logic                     req_valid,
   input  logic                     req_is_dma,
   input  logic                     req_write,
   input  logic [ADDR_W-1:0]        req_addr,
   output logic                     dec_valid,
   output logic                     dec_block,
   output logic                     dec_err,
   output logic                     dec_drop_wr,
   output logic                     dec_to_xlate,
   output logic [DATA_W-1:0]        dec_rdata,
   output logic                     prot_ok
);
   localparam int PAGE_W = ADDR_W - GRAN_W;
   localparam int N_WIN  = 2;

   generate
      if (ADDR_W <= 32) begin : g_bad_addr
         $error("ADDR_W must reach above 4 GB");
      end
      if (GRAN_W < 1 || GRAN_W >= 32) begin : g_bad_gran
         $error("GRAN_W must lie in 1..31");
      end
      if (PAGE_W < 3) begin : g_bad_page
         $error("page field too narrow for control bits");
      end
   endgenerate

   logic              glob_en;
   logic              lo_en;
   logic              hi_en;
   logic [PAGE_W-1:0] lo_base;
   logic [PAGE_W-1:0] lo_lim;
   logic [PAGE_W-1:0] hi_base;
   logic [PAGE_W-1:0] hi_lim;

   dpf_cfg #(.PAGE_W(PAGE_W)) u_cfg (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (cfg_we),
      .sel     (cfg_addr),
      .wdata   (cfg_wdata),
      .glob_en (glob_en),
      .lo_en   (lo_en),
      .hi_en   (hi_en),
      .lo_base (lo_base),
      .lo_lim  (lo_lim),
      .hi_base (hi_base),
      .hi_lim  (hi_lim)
   );

   logic [PAGE_W-1:0] w_base [N_WIN];
   logic [PAGE_W-1:0] w_lim  [N_WIN];
   logic [N_WIN-1:0]  w_en;
   logic [N_WIN-1:0]  w_ok;
   logic [N_WIN-1:0]  w_hit;

   assign w_base[0] = lo_base;
   assign w_lim[0]  = lo_lim;
   assign w_en[0]   = glob_en && lo_en;
   assign w_base[1] = hi_base;
   assign w_lim[1]  = hi_lim;
   assign w_en[1]   = glob_en && hi_en;

   generate
      for (genvar i = 0; i < N_WIN; i++) begin : g_win
         dpf_window #(
            .ADDR_W  (ADDR_W),
            .GRAN_W  (GRAN_W),
            .IS_HIGH (i == 1)
         ) u_win (
            .base   (w_base[i]),
            .lim    (w_lim[i]),
            .en     (w_en[i]),
            .addr   (req_addr),
            .cfg_ok (w_ok[i]),
            .hit    (w_hit[i])
         );
      end
   endgenerate

   assign prot_ok = glob_en && (&w_ok);

   dpf_resp #(.DATA_W(DATA_W)) u_resp (
      .clk          (clk),
      .rst_n        (rst_n),
      .req_valid    (req_valid),
      .req_is_dma   (req_is_dma),
      .req_write    (req_write),
      .remap_en     (remap_en),
      .win_hit      (|w_hit),
      .dec_valid    (dec_valid),
      .dec_block    (dec_block),
      .dec_err      (dec_err),
      .dec_drop_wr  (dec_drop_wr),
      .dec_to_xlate (dec_to_xlate),
      .dec_rdata    (dec_rdata)
   );
endmodule

// File: rtl/dpf_chk.sv
module dpf_chk #(
   parameter int DATA_W = 64
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cfg_we,
   input logic              req_valid,
   input logic              req_is_dma,
   input logic              req_write,
   input logic              dec_valid,
   input logic              dec_block,
   input logic              dec_err,
   input logic              dec_drop_wr,
   input logic              dec_to_xlate,
   input logic [DATA_W-1:0] dec_rdata,
   input logic              prot_ok
);
   // R4
   cpu_never_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_is_dma) |=> !dec_block);

   // R9
   blocked_read_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_is_dma && !req_write) |=> (dec_block ? (&dec_rdata && dec_err) : (dec_rdata == '0)));

   // R9
   blocked_write_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_write) |=> (dec_drop_wr == dec_block));

   // R1
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> (!dec_valid && !dec_block && !dec_err && !dec_to_xlate));

   // R6
   xlate_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dec_to_xlate |-> (dec_valid && !dec_block));

   // R8
   status_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_we |=> $stable(prot_ok));
endmodule

bind dma_prot_filter dpf_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/sim_dma_prot_filter.sv
`timescale 1ns/1ps
module sim_dma_prot_filter;
   localparam int AW = 39;
   localparam int PW = 19;
   localparam int DW = 64;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_we = 1'b0;
   logic [2:0]    cfg_addr = '0;
   logic [PW-1:0] cfg_wdata = '0;
   logic          remap_en = 1'b0;
   logic          req_valid = 1'b0;
   logic          req_is_dma = 1'b0;
   logic          req_write = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic          dec_valid, dec_block, dec_err, dec_drop_wr, dec_to_xlate, prot_ok;
   logic [DW-1:0] dec_rdata;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   dma_prot_filter u0 (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .remap_en(remap_en), .req_valid(req_valid),
      .req_is_dma(req_is_dma), .req_write(req_write), .req_addr(req_addr),
      .dec_valid(dec_valid), .dec_block(dec_block), .dec_err(dec_err),
      .dec_drop_wr(dec_drop_wr), .dec_to_xlate(dec_to_xlate),
      .dec_rdata(dec_rdata), .prot_ok(prot_ok)
   );

   task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic wr_cfg(input logic [2:0] a, input logic [PW-1:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   // drive one request; outputs sampled on the following falling edge
   task automatic send(input logic dma, input logic wr, input logic [AW-1:0] addr,
                       input logic rmp, input logic exp_blk, input string tag);
      @(negedge clk);
      req_valid = 1'b1; req_is_dma = dma; req_write = wr; req_addr = addr; remap_en = rmp;
      @(negedge clk);
      check({tag, " valid"}, DW'(dec_valid), DW'(1));
      check({tag, " block"}, DW'(dec_block), DW'(exp_blk));
      check({tag, " err"}, DW'(dec_err), DW'(exp_blk));
      check({tag, " drop"}, DW'(dec_drop_wr), DW'(exp_blk && wr));
      check({tag, " rdata"}, dec_rdata, (exp_blk && !wr) ? '1 : '0);
      check({tag, " xlate"}, DW'(dec_to_xlate), DW'(dma && !exp_blk && rmp));
      req_valid = 1'b0; remap_en = 1'b0;
   endtask

   task automatic program_ok();
      wr_cfg(3'd1, 19'h00010);
      wr_cfg(3'd2, 19'h0001F);
      wr_cfg(3'd3, 19'h01000);
      wr_cfg(3'd4, 19'h01003);
      wr_cfg(3'd0, 19'h7);
   endtask

   task automatic t_reset();
      @(negedge clk);
      check("R1 dec_valid", DW'(dec_valid), 0);
      check("R1 dec_block", DW'(dec_block), 0);
      check("R1 rdata", dec_rdata, 0);
      check("R1 prot_ok", DW'(prot_ok), 0);
      send(1'b1, 1'b0, 39'h0, 1'b0, 1'b0, "R1 unconfigured");
   endtask

   task automatic t_low();
      program_ok();
      check("R8 R10 prot_ok set", DW'(prot_ok), 1);
      send(1'b1, 1'b0, 39'h000_0100_0000, 1'b0, 1'b1, "R2 R9 low base read");
      send(1'b1, 1'b0, 39'h000_01FF_FFFF, 1'b0, 1'b1, "R2 low last byte");
      send(1'b1, 1'b0, 39'h000_0200_0000, 1'b0, 1'b0, "R2 R9 low above");
      send(1'b1, 1'b1, 39'h000_00FF_FFFF, 1'b0, 1'b0, "R2 low below");
   endtask

   task automatic t_high();
      send(1'b1, 1'b1, 39'h001_0000_0000, 1'b0, 1'b1, "R3 R9 high base write");
      send(1'b1, 1'b0, 39'h001_003F_FFFF, 1'b0, 1'b1, "R3 high last byte");
      send(1'b1, 1'b1, 39'h001_0040_0000, 1'b0, 1'b0, "R3 high above");
   endtask

   task automatic t_cpu();
      send(1'b0, 1'b0, 39'h000_0100_0000, 1'b0, 1'b0, "R4 cpu low");
      send(1'b0, 1'b1, 39'h001_0000_0000, 1'b0, 1'b0, "R4 cpu high");
   endtask

   task automatic t_remap();
      send(1'b1, 1'b0, 39'h000_0100_0000, 1'b1, 1'b1, "R6 remap on hit");
      send(1'b1, 1'b0, 39'h000_0300_0000, 1'b1, 1'b0, "R6 remap on pass");
      send(1'b1, 1'b0, 39'h000_0300_0000, 1'b0, 1'b0, "R6 remap off pass");
   endtask

   task automatic t_global_off();
      wr_cfg(3'd0, 19'h6);
      check("R8 prot_ok global off", DW'(prot_ok), 0);
      send(1'b1, 1'b0, 39'h000_0100_0000, 1'b0, 1'b0, "R5 low off");
      send(1'b1, 1'b1, 39'h001_0000_0000, 1'b1, 1'b0, "R5 high off");
      wr_cfg(3'd0, 19'h7);
   endtask

   task automatic t_invalid();
      wr_cfg(3'd2, 19'h01000);
      check("R7 R8 low lim at 4GB status", DW'(prot_ok), 0);
      send(1'b1, 1'b0, 39'h000_0100_0000, 1'b0, 1'b0, "R7 low lim at 4GB");
      wr_cfg(3'd2, 19'h0001F);
      check("R8 status restored", DW'(prot_ok), 1);
      wr_cfg(3'd3, 19'h00FFF);
      send(1'b1, 1'b0, 39'h001_0000_0000, 1'b0, 1'b0, "R7 high base below 4GB");
      wr_cfg(3'd3, 19'h01004);
      send(1'b1, 1'b0, 39'h001_0000_0000, 1'b0, 1'b0, "R7 high base over limit");
      check("R7 status inverted", DW'(prot_ok), 0);
      send(1'b1, 1'b0, 39'h000_0100_0000, 1'b0, 1'b1, "R7 low still active");
      wr_cfg(3'd3, 19'h01000);
   endtask

   task automatic t_unmapped();
      wr_cfg(3'd5, 19'h0);
      wr_cfg(3'd7, 19'h0);
      check("R10 unmapped status", DW'(prot_ok), 1);
      send(1'b1, 1'b0, 39'h000_0100_0000, 1'b0, 1'b1, "R10 unmapped keeps low");
      send(1'b1, 1'b1, 39'h001_0000_0000, 1'b0, 1'b1, "R10 unmapped keeps high");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_low();
      t_high();
      t_cpu();
      t_remap();
      t_global_off();
      t_invalid();
      t_unmapped();
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual hung expected done");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule